// File: doc/BRIEF.md
# Grouped-Priority Channel Arbiter with Interrupt Status

This block decides which of up to 32 DMA channels gets the shared memory port next. Each channel drives a request line. Channels are ranked by a fixed priority level that comes from their index, so channels n and n+16 always share a level. Among the requesters at the best level present, the grant rotates round-robin. A grant, once issued, stays with its channel until that channel reports the end of its burst. The arbiter can then hand the port to the next winner on the same clock edge.

Beside the arbiter, the block gathers each channel's interrupt flags. Each flag is gated by its own enable, and the enabled flags are folded into a registered status vector with one bit per channel. A single interrupt line is the OR of that vector. A status bit clears as soon as its channel's enabled flags are all low.

Top module: `arb_grp_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `gnt`, `gnt_valid`, `irq_status` and `irq_out` are all zero.
- R2: A channel's level is bits 3:2 of its index, and level 0 is the most urgent. A new grant always goes to a requester whose level number is the lowest among all current requesters. For example, channel 17 (level 0) wins over channel 5 (level 1).
- R3: Within one level, each level remembers the index it last granted; this is index NUM_CH-1 after reset. The next grant at that level goes to the first requesting member of the level found when counting up from that index and wrapping at NUM_CH.
- R4: While a grant is held and `burst_done` is low, the grant does not change, whatever the requests do.
- R5: `gnt` is zero or one-hot. When `gnt_valid` is high, bit `gnt_idx` of `gnt` is set, and it is the only bit set.
- R6: From idle, a request seen at a rising edge produces its grant in the cycle right after that edge.
- R7: `burst_done` while no grant is held has no effect. With no requests, a held grant drops in the cycle after `burst_done`.
- R8: `irq_status[n]` equals, one cycle later, the OR over k of `irq_flags[n*NFLAG+k] & irq_enables[n*NFLAG+k]`.
- R9: `irq_out` is high exactly when some bit of `irq_status` is set, in the same cycle.
- R10: When `burst_done` arrives with requests present, the next winner is granted on that same edge, with no idle cycle between grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CH | Per-channel request for the memory port |
| burst_done | input | 1 | The granted channel has finished its burst |
| irq_flags | input | NUM_CH*NFLAG | Per-channel interrupt flags; channel n uses bits n*NFLAG up to n*NFLAG+NFLAG-1 |
| irq_enables | input | NUM_CH*NFLAG | Enable for each flag, in the same layout as irq_flags |
| gnt | output | NUM_CH | One-hot grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_idx | output | IDX_W | Index of the granted channel |
| irq_status | output | NUM_CH | Registered per-channel interrupt status |
| irq_out | output | 1 | OR of all status bits |

## Verification
A grant or a change of grant is due in the cycle after the rising edge that sees the request or `burst_done`. A status bit is due one cycle after the flags and enables that cause it, and `irq_out` follows the status vector with no further delay. The reference model updates at each rising edge from the inputs the bench drove at the falling edge before. All outputs are compared at the next falling edge, so every check lands on the cycle where its result is due. Directed phases cover level ordering, rotation, holding, idle `burst_done` and back-to-back handover, and a long random phase follows them.

// File: rtl/arb_grp_pkg.sv
package arb_grp_pkg;

    localparam int NUM_LEVELS = 4;
    localparam int MAX_CH     = 32;

    typedef logic [1:0] level_t;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

    // Priority level is taken from bits 3:2 of a channel index.
    function automatic level_t level_of(input int unsigned idx);
        return level_t'(idx[3:2]);
    endfunction

endpackage

// File: rtl/arb_grp_level_pick.sv
module arb_grp_level_pick
    import arb_grp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5,
    parameter int LEVEL  = 0
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              hit,
    output logic [IDX_W-1:0]  pick
);

    logic [NUM_CH-1:0] member;
    logic [NUM_CH-1:0] cand;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_member
        assign member[i] = (level_of(i) == level_t'(LEVEL));
    end

    assign cand = req & member;

    // Scan upward from the index after the last winner, wrapping around.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int c;
            c = (int'(last_idx) + k) % NUM_CH;
            if (!hit && cand[c]) begin
                hit  = 1'b1;
                pick = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/arb_grp_grant.sv
module arb_grp_grant
    import arb_grp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_LEVELS-1:0]                 level_hit,
    input  logic [NUM_LEVELS-1:0][IDX_W-1:0]      level_pick,
    input  logic                                  burst_done,
    output logic                                  owner_valid,
    output logic [IDX_W-1:0]                      owner_idx,
    output logic [NUM_LEVELS-1:0][IDX_W-1:0]      last_idx
);

    arb_state_e       state_q;
    logic             win_any;
    level_t           win_lvl;
    logic [IDX_W-1:0] win_idx;
    logic             rearb;

    // Lowest-numbered level with a requester wins.
    always_comb begin
        win_any = 1'b0;
        win_lvl = '0;
        for (int lv = NUM_LEVELS - 1; lv >= 0; lv--) begin
            if (level_hit[lv]) begin
                win_any = 1'b1;
                win_lvl = level_t'(lv);
            end
        end
    end

    assign win_idx = level_pick[win_lvl];
    assign rearb   = (state_q == ARB_IDLE) || burst_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            owner_idx <= '0;
            for (int lv = 0; lv < NUM_LEVELS; lv++) begin
                last_idx[lv] <= IDX_W'(NUM_CH - 1);
            end
        end else if (rearb) begin
            if (win_any) begin
                state_q            <= ARB_OWNED;
                owner_idx          <= win_idx;
                last_idx[win_lvl]  <= win_idx;
            end else begin
                state_q <= ARB_IDLE;
            end
        end
    end

    assign owner_valid = (state_q == ARB_OWNED);

endmodule

// File: rtl/arb_grp_irq.sv
module arb_grp_irq #(
    parameter int NUM_CH = 32,
    parameter int NFLAG  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH*NFLAG-1:0] irq_flags,
    input  logic [NUM_CH*NFLAG-1:0] irq_enables,
    output logic [NUM_CH-1:0]       irq_status,
    output logic                    irq_out
);

    logic [NUM_CH-1:0] active;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign active[n] = |(irq_flags[n*NFLAG +: NFLAG] & irq_enables[n*NFLAG +: NFLAG]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status <= '0;
        end else begin
            irq_status <= active;
        end
    end

    assign irq_out = |irq_status;

endmodule

// File: rtl/arb_grp_arbiter.sv
module arb_grp_arbiter
    import arb_grp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int NFLAG  = 3,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       req,
    input  logic                    burst_done,
    input  logic [NUM_CH*NFLAG-1:0] irq_flags,
    input  logic [NUM_CH*NFLAG-1:0] irq_enables,
    output logic [NUM_CH-1:0]       gnt,
    output logic                    gnt_valid,
    output logic [IDX_W-1:0]        gnt_idx,
    output logic [NUM_CH-1:0]       irq_status,
    output logic                    irq_out
);

    logic [NUM_LEVELS-1:0]            level_hit;
    logic [NUM_LEVELS-1:0][IDX_W-1:0] level_pick;
    logic [NUM_LEVELS-1:0][IDX_W-1:0] last_idx;

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
        arb_grp_level_pick #(
            .NUM_CH (NUM_CH),
            .IDX_W  (IDX_W),
            .LEVEL  (lv)
        ) pick_i (
            .req      (req),
            .last_idx (last_idx[lv]),
            .hit      (level_hit[lv]),
            .pick     (level_pick[lv])
        );
    end

    arb_grp_grant #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) grant_i (
        .clk         (clk),
        .rst         (rst),
        .level_hit   (level_hit),
        .level_pick  (level_pick),
        .burst_done  (burst_done),
        .owner_valid (gnt_valid),
        .owner_idx   (gnt_idx),
        .last_idx    (last_idx)
    );

    always_comb begin
        gnt = '0;
        if (gnt_valid) begin
            gnt[gnt_idx] = 1'b1;
        end
    end

    arb_grp_irq #(
        .NUM_CH (NUM_CH),
        .NFLAG  (NFLAG)
    ) irq_i (
        .clk         (clk),
        .rst         (rst),
        .irq_flags   (irq_flags),
        .irq_enables (irq_enables),
        .irq_status  (irq_status),
        .irq_out     (irq_out)
    );

endmodule

// File: rtl/arb_grp_chk.sv
module arb_grp_chk
    import arb_grp_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int NFLAG  = 3,
    parameter int IDX_W  = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       req,
    input logic                    burst_done,
    input logic [NUM_CH*NFLAG-1:0] irq_flags,
    input logic [NUM_CH*NFLAG-1:0] irq_enables,
    input logic [NUM_CH-1:0]       gnt,
    input logic                    gnt_valid,
    input logic [IDX_W-1:0]        gnt_idx,
    input logic [NUM_CH-1:0]       irq_status,
    input logic                    irq_out
);

    logic              rst_q;
    level_t            best_lvl;
    logic [NUM_CH-1:0] act;

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        best_lvl = 2'd3;
        for (int lv = NUM_LEVELS - 1; lv >= 0; lv--) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (req[i] && level_of(i) == level_t'(lv)) best_lvl = level_t'(lv);
            end
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_act
        assign act[n] = |(irq_flags[n*NFLAG +: NFLAG] & irq_enables[n*NFLAG +: NFLAG]);
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (gnt == '0 && !gnt_valid && irq_status == '0 && !irq_out));

    a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && (gnt_valid == (gnt != '0)));

    a_r5_idx_match: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> gnt[gnt_idx]);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !burst_done) |=> (gnt_valid && $stable(gnt_idx)));

    a_r6_grant_next: assert property (@(posedge clk) disable iff (rst)
        (!gnt_valid && req != '0) |=> gnt_valid);

    a_r7_idle_done: assert property (@(posedge clk) disable iff (rst)
        (!gnt_valid && req == '0) |=> !gnt_valid);

    a_r10_handover: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && burst_done && req != '0) |=> gnt_valid);

    a_r2_best_level: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && gnt_valid && (!$past(gnt_valid) || $past(burst_done)))
            |-> (level_of(int'(gnt_idx)) == $past(best_lvl)));

    a_r8_status: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> (irq_status == $past(act)));

endmodule

bind arb_grp_arbiter arb_grp_chk #(
    .NUM_CH (NUM_CH),
    .NFLAG  (NFLAG),
    .IDX_W  (IDX_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .burst_done  (burst_done),
    .irq_flags   (irq_flags),
    .irq_enables (irq_enables),
    .gnt         (gnt),
    .gnt_valid   (gnt_valid),
    .gnt_idx     (gnt_idx),
    .irq_status  (irq_status),
    .irq_out     (irq_out)
);

// File: tb/arb_grp_arbiter_tb_top.sv
`timescale 1ns/1ps
module arb_grp_arbiter_tb_top;

    localparam int NCH = 32;
    localparam int NFL = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   req = '0;
    logic             burst_done = 1'b0;
    logic [NCH*NFL-1:0] irq_flags = '0;
    logic [NCH*NFL-1:0] irq_enables = '0;
    logic [NCH-1:0]   gnt;
    logic             gnt_valid;
    logic [4:0]       gnt_idx;
    logic [NCH-1:0]   irq_status;
    logic             irq_out;

    always #2 clk = ~clk;

    arb_grp_arbiter #(.NUM_CH(NCH), .NFLAG(NFL)) dut_i (
        .clk(clk), .rst(rst), .req(req), .burst_done(burst_done),
        .irq_flags(irq_flags), .irq_enables(irq_enables),
        .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
        .irq_status(irq_status), .irq_out(irq_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1 reset";
    bit    started = 0;

    // Behavioural reference model
    bit       m_held;
    int       m_owner;
    int       m_last[4];
    bit [NCH-1:0] m_stat;

    function automatic int lvl(input int i);
        return (i >> 2) & 3;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_held  = 0;
            m_owner = 0;
            for (int l = 0; l < 4; l++) m_last[l] = NCH - 1;
            m_stat  = '0;
        end else begin
            bit [NCH-1:0] ns;
            ns = '0;
            for (int n = 0; n < NCH; n++)
                for (int k = 0; k < NFL; k++)
                    if (irq_flags[n*NFL+k] && irq_enables[n*NFL+k]) ns[n] = 1'b1;
            if (!m_held || burst_done) begin
                int best;
                best = -1;
                for (int n = 0; n < NCH; n++)
                    if (req[n] && (best < 0 || lvl(n) < best)) best = lvl(n);
                if (best < 0) begin
                    m_held = 0;
                end else begin
                    for (int k = 1; k <= NCH; k++) begin
                        int c;
                        c = (m_last[best] + k) % NCH;
                        if (req[c] && lvl(c) == best) begin
                            m_owner = c;
                            m_last[best] = c;
                            break;
                        end
                    end
                    m_held = 1;
                end
            end
            m_stat = ns;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [NCH-1:0] eg;
            eg = m_held ? (NCH'(1) << m_owner) : '0;
            n_cmp++;
            if (gnt !== eg) begin
                n_bad++;
                $display("FAIL [%s] R2 R3 R4 R5 gnt: actual %h expected %h", phase, gnt, eg);
            end
            n_cmp++;
            if (gnt_valid !== m_held || (m_held && gnt_idx !== 5'(m_owner))) begin
                n_bad++;
                $display("FAIL [%s] R5 R6 R7 valid/idx: actual %b/%0d expected %b/%0d",
                         phase, gnt_valid, gnt_idx, m_held, m_owner);
            end
            n_cmp++;
            if (irq_status !== m_stat) begin
                n_bad++;
                $display("FAIL [%s] R8 irq_status: actual %h expected %h", phase, irq_status, m_stat);
            end
            n_cmp++;
            if (irq_out !== (m_stat != '0)) begin
                n_bad++;
                $display("FAIL [%s] R9 irq_out: actual %b expected %b", phase, irq_out, (m_stat != '0));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        phase = "R1 after reset";
        step(3);

        phase = "R2 level order";
        req = '0; req[5] = 1; req[17] = 1;
        step(3);
        burst_done = 1; step(1); burst_done = 0;
        req = '0; req[12] = 1; req[8] = 1; req[30] = 1;
        step(2);
        burst_done = 1; step(1); burst_done = 0;
        req = '0;
        burst_done = 1; step(1); burst_done = 0;
        step(2);

        phase = "R3 rotation";
        req = '0; req[0] = 1; req[1] = 1; req[16] = 1; req[19] = 1;
        burst_done = 1;
        step(10);
        req = '0; req[22] = 1; req[6] = 1;
        step(6);
        burst_done = 0; req = '0;
        step(1);
        burst_done = 1; step(1); burst_done = 0;
        step(2);

        phase = "R4 hold";
        req = '0; req[28] = 1;
        step(1);
        req = '0; req[2] = 1; req[3] = 1;
        step(6);
        req = '0;
        step(3);
        burst_done = 1; step(1); burst_done = 0;
        step(2);

        phase = "R7 idle done";
        burst_done = 1; step(5); burst_done = 0;
        step(2);

        phase = "R6 single request";
        req[9] = 1; step(1); req = '0;
        step(4);
        burst_done = 1; step(1); burst_done = 0;
        step(2);

        phase = "R10 handover";
        req = '0; req[3] = 1; req[19] = 1; req[7] = 1;
        step(1);
        burst_done = 1; step(4);
        req = '0; step(1);
        burst_done = 0; step(2);

        phase = "R8 flag gating";
        irq_flags = '1; irq_enables = '0; step(3);
        irq_enables[5*NFL+1] = 1; step(3);
        irq_flags[5*NFL+1] = 0; step(3);
        irq_enables = '0; irq_enables[31*NFL+2] = 1; irq_flags = '0; irq_flags[31*NFL+2] = 1; step(2);

        phase = "R9 combined line";
        irq_flags = '0; step(3);
        irq_flags[0] = 1; irq_enables[0] = 1; step(2);
        irq_flags = '0; irq_enables = '0; step(2);

        phase = "R2 R3 R4 R8 R9 random";
        for (int i = 0; i < 4000; i++) begin
            logic [NCH-1:0] r;
            r = $urandom & $urandom;
            if (($urandom % 5) == 0) r = '0;
            req = r;
            burst_done = (($urandom % 3) == 0);
            irq_flags = {$urandom, $urandom, $urandom};
            irq_enables = {$urandom, $urandom, $urandom};
            step(1);
        end
        req = '0; burst_done = 0; irq_flags = '0;
        step(3);

        phase = "R1 mid-run reset";
        req[4] = 1; irq_flags = '1; irq_enables = '1; step(2);
        rst = 1; step(2);
        rst = 0; req = '0; irq_flags = '0; step(3);

        finish_run();
    end

endmodule